// File: doc/BRIEF.md
# Interrupt Coalescing Timer

This block sits between the completion logic of a 10/100 Mb/s Ethernet MAC and its interrupt status logic. Each time a frame finishes, the transmit or receive side raises a one-cycle done pulse. The block groups these pulses and raises a one-cycle interrupt pulse for a direction in two cases: when the number of pending completions reaches a programmed threshold, or when a programmed timeout ends. The timeout starts at the first completion that is not yet reported. Software can then trade interrupt rate against latency separately for each direction.

The timeout is counted in cycle units measured in bit times. A shared `bit_tick` input pulses once per 100 Mb/s bit time. A normal cycle is `NORM_TICKS` ticks and a long cycle is `LONG_TICKS` ticks. At 10 Mb/s each cycle lasts `SLOW_MULT` times as long. With the default parameters (512, 8192, 10) and a 100 Mb/s bit-time tick, the cycles are 5.12 µs and 81.92 µs at 100 Mb/s, and 51.2 µs and 819.2 µs at 10 Mb/s. The 16-bit control word holds one byte per direction. Each byte has a cycle-length select, a 3-bit threshold and a 4-bit timeout count.

Top module: `irq_coalesce`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, both `tx_irq` and `rx_irq` are low and no completion is pending.
- R2: The control word bits are: transmit long-cycle select at bit 15, transmit threshold at bits 14:12, transmit timeout at bits 11:8, receive long-cycle select at bit 7, receive threshold at bits 6:4, receive timeout at bits 3:0.
- R3: With threshold n, the n-th completion since the last interrupt of that direction makes the interrupt output high for exactly one cycle, in the cycle after the done pulse. A threshold of 0 behaves as 1.
- R4: A timeout field of 0 disables the timer path. Completions below the threshold then stay pending for any number of ticks and produce no interrupt.
- R5: With a timeout field of t > 0, the timer starts counting `bit_tick` pulses at the clock edge after the first pending completion. The interrupt is high in the cycle after the edge where the (t × cycle length)-th tick is counted.
- R6: The cycle length is `NORM_TICKS` when the long-cycle select is 0 and `LONG_TICKS` when it is 1, with `speed_100` high. With `speed_100` low it is multiplied by `SLOW_MULT`.
- R7: Each interrupt pulse clears the direction's event count and timer. A completion that arrives in the same cycle as a timer expiry is merged into that interrupt and does not stay pending.
- R8: If the threshold is reached in the same cycle that the timer expires, exactly one interrupt pulse results.
- R9: The two directions are independent. Completions and settings of one direction never cause an interrupt on the other.
- R10: A control word of threshold 1 and timeout 0 for a direction gives one interrupt pulse per completion, including on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 16 | Coalescing control word (see R2) |
| speed_100 | input | 1 | 1 = 100 Mb/s link, 0 = 10 Mb/s link |
| bit_tick | input | 1 | One pulse per 100 Mb/s bit time |
| tx_done | input | 1 | Transmit completion pulse |
| rx_done | input | 1 | Receive completion pulse |
| tx_irq | output | 1 | Coalesced transmit interrupt pulse |
| rx_irq | output | 1 | Coalesced receive interrupt pulse |

## Verification
The bench measures the exact tick count from a first completion to the timer interrupt for both cycle lengths and both speeds. A design with an off-by-one in the timer start would fire one tick early or late. A design that mixed up the speed scaling would be off by a whole factor. A completion is placed on the exact cycle of timer expiry twice: once below the threshold, where a design that kept the event pending would later fire a second interrupt, and once reaching the threshold, where a design that merged the two causes badly would fire twice. Remainders left below threshold with the timer disabled, threshold 0, and asymmetric settings per direction catch a timer that runs when disabled, a division by the raw threshold field, and crossed control bits.

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int NORM_TICKS = 512,
  parameter int LONG_TICKS = 8192,
  parameter int SLOW_MULT  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ctrl,
  input  logic        speed_100,
  input  logic        bit_tick,
  input  logic        tx_done,
  input  logic        rx_done,
  output logic        tx_irq,
  output logic        rx_irq
);

  localparam int MAX_TICKS = 15 * LONG_TICKS * SLOW_MULT;
  localparam int TW        = $clog2(MAX_TICKS + 1);

  logic [1:0] done_v;
  logic [1:0] irq_v;

  assign done_v = {rx_done, tx_done};
  assign tx_irq = irq_v[0];
  assign rx_irq = irq_v[1];

  for (genvar c = 0; c < 2; c++) begin : g_dir
    logic [7:0]    fld;
    logic [2:0]    cnt;
    logic [TW-1:0] tmr;
    logic [TW-1:0] limit;
    logic [3:0]    nxt_cnt;
    logic [2:0]    thr_eff;
    logic          pend, thr_hit, tmr_hit, fire;
    int            base;

    assign fld = ctrl[8*(1-c) +: 8];

    always_comb begin
      base = fld[7] ? LONG_TICKS : NORM_TICKS;
      if (!speed_100) base = base * SLOW_MULT;
      limit = TW'(base * int'(fld[3:0]));
    end

    assign thr_eff = (fld[6:4] == 3'd0) ? 3'd1 : fld[6:4];
    assign nxt_cnt = {1'b0, cnt} + {3'b000, done_v[c]};
    assign pend    = (cnt != 3'd0);
    assign thr_hit = done_v[c] && (nxt_cnt >= {1'b0, thr_eff});
    assign tmr_hit = pend && (fld[3:0] != 4'd0) && bit_tick &&
                     (({1'b0, tmr} + 1'b1) >= {1'b0, limit});
    assign fire    = thr_hit || tmr_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt      <= '0;
        tmr      <= '0;
        irq_v[c] <= 1'b0;
      end else begin
        irq_v[c] <= fire;
        if (fire) begin
          cnt <= '0;
          tmr <= '0;
        end else begin
          cnt <= nxt_cnt[2:0];
          if (!pend)
            tmr <= '0;
          else if (bit_tick && tmr != TW'(MAX_TICKS))
            tmr <= tmr + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] ctrl,
  input logic        bit_tick,
  input logic        tx_done,
  input logic        rx_done,
  input logic        tx_irq,
  input logic        rx_irq
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!tx_irq && !rx_irq));

  // R3
  tx_thr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && ctrl[14:12] <= 3'd1) |=> tx_irq);

  // R4
  tx_no_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[11:8] == 4'd0 && !tx_done) |=> !tx_irq);

  // R4
  rx_no_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3:0] == 4'd0 && !rx_done) |=> !rx_irq);

  // R7
  tx_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && tx_done && ctrl[14:12] >= 3'd2 && ctrl[11:8] == 4'd0) |=> !tx_irq);

  // R9
  rx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(rx_done || bit_tick));

endmodule

bind irq_coalesce irq_coalesce_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .bit_tick(bit_tick),
  .tx_done(tx_done), .rx_done(rx_done), .tx_irq(tx_irq), .rx_irq(rx_irq)
);

// File: tb/irq_coalesce_tb_top.sv
module irq_coalesce_tb_top;
  localparam int NT = 8;
  localparam int LT = 32;
  localparam int SM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ctrl = 16'h0000;
  logic speed_100 = 1'b1;
  logic bit_tick = 1'b0;
  logic tx_done = 1'b0;
  logic rx_done = 1'b0;
  logic tx_irq, rx_irq;

  int total = 0, fails = 0;
  int mc[2], mt[2];
  bit me[2];
  bit obs_tx, obs_rx;
  int ptx = 0, prx = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  irq_coalesce #(.NORM_TICKS(NT), .LONG_TICKS(LT), .SLOW_MULT(SM)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .speed_100(speed_100),
    .bit_tick(bit_tick), .tx_done(tx_done), .rx_done(rx_done),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin mc[c] = 0; mt[c] = 0; me[c] = 0; end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int f, len, lim, th;
        bit ev, pend, fire;
        f = (c == 0) ? int'(ctrl[15:8]) : int'(ctrl[7:0]);
        ev = (c == 0) ? tx_done : rx_done;
        len = ((f >> 7) & 1) ? LT : NT;
        if (!speed_100) len = len * SM;
        lim = (f & 15) * len;
        th = (f >> 4) & 7;
        if (th == 0) th = 1;
        pend = (mc[c] > 0);
        fire = 0;
        if (ev) begin mc[c]++; if (mc[c] >= th) fire = 1; end
        if (pend && lim > 0 && bit_tick) begin mt[c]++; if (mt[c] >= lim) fire = 1; end
        if (fire) begin mc[c] = 0; mt[c] = 0; end
        me[c] = fire;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit r, input bit k);
    @(negedge clk);
    obs_tx = tx_irq;
    obs_rx = rx_irq;
    check(obs_tx == me[0], {cur_tag, " tx per-cycle"}, obs_tx, me[0]);
    check(obs_rx == me[1], {cur_tag, " rx per-cycle"}, obs_rx, me[1]);
    if (obs_tx) ptx++;
    if (obs_rx) prx++;
    tx_done = t;
    rx_done = r;
    bit_tick = k;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1);
  endtask

  task automatic meas(input int d, input int n_exp, input string tag);
    int got;
    got = -1;
    cyc(d == 0, d == 1, 0);
    for (int i = 1; i <= n_exp + 6; i++) begin
      cyc(0, 0, 1);
      if (got < 0 && ((d == 0) ? obs_tx : obs_rx)) got = i - 1;
    end
    check(got == n_exp, tag, got, n_exp);
  endtask

  initial begin
    #1_000_000;
    fails++;
    total++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cur_tag = "R1";
    for (int i = 0; i < 3; i++) cyc(0, 0, 0);
    check(tx_irq == 1'b0 && rx_irq == 1'b0, "R1 reset outputs", {tx_irq, rx_irq}, 0);
    rst_n = 1'b1;
    cyc(0, 0, 1);
    check(tx_irq == 1'b0 && rx_irq == 1'b0, "R1 after release", {tx_irq, rx_irq}, 0);

    cur_tag = "R10";
    ctrl = 16'h1010; ptx = 0; prx = 0;
    for (int i = 0; i < 3; i++) begin cyc(1, 0, 0); cyc(0, 1, 1); end
    cyc(1, 1, 0); cyc(1, 0, 0); idle(3);
    check(ptx == 5, "R10 tx one per frame", ptx, 5);
    check(prx == 4, "R10 rx one per frame", prx, 4);

    cur_tag = "R3";
    ctrl = 16'h3000; ptx = 0; prx = 0;
    for (int i = 0; i < 7; i++) begin cyc(1, 0, 0); cyc(0, 0, 0); end
    idle(2);
    check(ptx == 2, "R3 threshold 3 of 7", ptx, 2);
    cur_tag = "R4";
    idle(100);
    check(ptx == 2, "R4 timeout 0 keeps remainder", ptx, 2);
    cur_tag = "R3";
    cyc(1, 1, 0); cyc(1, 1, 0); idle(2);
    check(ptx == 3, "R3 remainder completes", ptx, 3);
    check(prx == 2, "R3 threshold 0 acts as 1", prx, 2);

    cur_tag = "R5";
    ctrl = 16'h7200; speed_100 = 1'b1;
    meas(0, 16, "R5 tx normal 2 cycles at 100");
    cur_tag = "R6";
    speed_100 = 1'b0;
    meas(0, 48, "R6 tx normal 2 cycles at 10");
    ctrl = 16'hF100; speed_100 = 1'b1;
    meas(0, 32, "R6 tx long 1 cycle at 100");
    cur_tag = "R2";
    ctrl = 16'h00F3; speed_100 = 1'b0;
    meas(1, 288, "R2 rx long 3 cycles at 10");
    ctrl = 16'h0071; speed_100 = 1'b1;
    meas(1, 8, "R2 rx normal 1 cycle at 100");

    cur_tag = "R7";
    ctrl = 16'h2000; ptx = 0;
    for (int i = 0; i < 4; i++) begin cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 0); end
    idle(2);
    check(ptx == 2, "R7 count cleared after pulse", ptx, 2);
    ctrl = 16'h7100; ptx = 0;
    cyc(1, 0, 0);
    for (int i = 0; i < 7; i++) cyc(0, 0, 1);
    cyc(1, 0, 1);
    idle(30);
    check(ptx == 1, "R7 event at expiry absorbed", ptx, 1);

    cur_tag = "R8";
    ctrl = 16'h2100; ptx = 0;
    cyc(1, 0, 0);
    for (int i = 0; i < 7; i++) cyc(0, 0, 1);
    cyc(1, 0, 1);
    idle(30);
    check(ptx == 1, "R8 coincident causes one pulse", ptx, 1);

    cur_tag = "R9";
    ctrl = 16'h1070; ptx = 0; prx = 0;
    for (int i = 0; i < 3; i++) begin cyc(1, 0, 0); cyc(0, 1, 0); end
    idle(2);
    check(ptx == 3, "R9 tx unaffected by rx", ptx, 3);
    check(prx == 0, "R9 rx held by own threshold", prx, 0);
    for (int i = 0; i < 4; i++) begin cyc(0, 1, 1); cyc(0, 0, 0); end
    idle(2);
    check(ptx == 3, "R9 rx events give no tx", ptx, 3);
    check(prx == 1, "R9 rx threshold 7 reached", prx, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule